// File: doc/BRIEF.md
# Multibank Row Command Sequencer

This block sits between a simple request stream and a banked memory device. Each request names a bank, a row and a column, says read or write, and may ask for the row to be closed automatically once the burst finishes. The sequencer remembers, for every bank, whether a row is open and which one. From that state it emits the shortest legal command sequence. A hit goes straight to the access command. A closed bank gets an activate first. A bank holding a different row is precharged, then activated, then accessed.

Each bank has its own gap counter, so one bank can wait out its spacing after an activate or precharge while a different bank receives commands. A refresh timer runs all the time and uses half its interval while the hot flag is high. When the timer expires, the sequencer closes every open bank and then issues a refresh, ahead of any waiting request.

The block issues at most one command per cycle. Each command is a one-cycle strobe with a 3-bit code, a bank index, an address field and an auto-close flag. A request stays presented until `reqReady` is seen high. The bank count must be a power of two.

Top module: `rowCmdSeq`

## Requirements
- R1: After reset no command is issued, `reqReady` is low, and every bank is treated as closed, so the first request to any bank starts with an activate.
- R2: A request to a closed bank first produces an activate (code 1) carrying that bank and the requested row on `cmdAddr`.
- R3: The read (code 2) or write (code 3) that follows an activate to the same bank comes exactly ACT_GAP cycles later, never sooner, with the column on `cmdAddr`.
- R4: A request whose row is already open in its bank produces the access command in the cycle after it is presented, with no activate or precharge.
- R5: A request to a bank holding a different row produces a precharge (code 4) to that bank, an activate PRE_GAP cycles later, and the access ACT_GAP cycles after that.
- R6: An access requested with auto-close carries `cmdAutoPre` high and leaves the bank closed. The next request to that bank, even for the same row, starts with an activate no sooner than PRE_GAP cycles after that access.
- R7: `cmdValid` is a single-cycle strobe with `cmdCode` 0 whenever it is low. `reqReady` is high exactly in the cycle before the request's access command appears.
- R8: When the refresh interval elapses, each open bank is precharged, and then a refresh (code 5) is issued before any waiting request is served. With no traffic, refreshes are REF_INTERVAL cycles apart.
- R9: While `hotFlag` is high, the refresh interval is REF_INTERVAL/2 cycles.
- R10: A command to one bank never changes the row state of another bank, so rows stay open in several banks at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; everything registers on the rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| hotFlag | input | 1 | High-temperature indication; halves the refresh interval |
| reqValid | input | 1 | A request is presented |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAutoPre | input | 1 | Close the row after this access |
| reqBank | input | BANK_W | Target bank |
| reqRow | input | ROW_W | Target row |
| reqCol | input | COL_W | Starting column |
| reqReady | output | 1 | Request is consumed at this clock edge |
| cmdValid | output | 1 | Command strobe, one cycle per command |
| cmdCode | output | 3 | 0 idle, 1 activate, 2 read, 3 write, 4 precharge, 5 refresh |
| cmdBank | output | BANK_W | Bank of the command (0 for refresh) |
| cmdAddr | output | ADDR_W | Row for activate, column for read/write, else 0 |
| cmdAutoPre | output | 1 | Access closes its row afterwards |

## Verification
The assertions assume that a presented request is held stable until `reqReady` is seen. They also assume that the bank field indexes a bank that exists, which the power-of-two bank count guarantees. The bench drives inputs only on falling edges. It changes the request fields only after the access command for the current request has been observed, and it uses bank numbers within range. The refresh scenarios begin only after a refresh that met no open bank, so the timer's phase is known before a request is timed against the expiry.

// File: rtl/rowseq_pkg.sv
package rowseq_pkg;

  typedef enum logic [2:0] {
    CMD_IDLE = 3'd0,
    CMD_ACT  = 3'd1,
    CMD_RD   = 3'd2,
    CMD_WR   = 3'd3,
    CMD_PRE  = 3'd4,
    CMD_REF  = 3'd5
  } seqCmd_e;

  // strobes from the controller to the datapath, at most one of the do* set
  typedef struct packed {
    logic doAct;
    logic doPre;
    logic doAccess;
    logic doRef;
    logic isWrite;
    logic autoPre;
  } seqStrobe_t;

endpackage

// File: rtl/rowSeqPath.sv
module rowSeqPath
  import rowseq_pkg::*;
#(
  parameter int NUM_BANKS    = 8,
  parameter int ROW_W        = 14,
  parameter int COL_W        = 10,
  parameter int ACT_GAP      = 3,
  parameter int PRE_GAP      = 2,
  parameter int REF_GAP      = 4,
  parameter int REF_INTERVAL = 7800,
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [BANK_W-1:0] selBank,
  input  logic [BANK_W-1:0] reqBank,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic [COL_W-1:0]  reqCol,
  input  logic              hotFlag,
  output logic              reqOpen,
  output logic              reqHit,
  output logic              reqBankReady,
  output logic              refPending,
  output logic              anyOpen,
  output logic [BANK_W-1:0] firstOpen,
  output logic              firstOpenReady,
  output logic              allReady,
  output logic              cmdValid,
  output logic [2:0]        cmdCode,
  output logic [BANK_W-1:0] cmdBank,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic              cmdAutoPre
);

  localparam int MAX_GAP0 = (ACT_GAP > PRE_GAP) ? ACT_GAP : PRE_GAP;
  localparam int MAX_GAP  = (MAX_GAP0 > REF_GAP) ? MAX_GAP0 : REF_GAP;
  localparam int GAP_W    = $clog2(MAX_GAP + 1);
  localparam int REF_W    = $clog2(REF_INTERVAL + 1);
  localparam logic [REF_W-1:0] FULL_LIM = REF_W'(REF_INTERVAL);
  localparam logic [REF_W-1:0] HALF_LIM = REF_W'(REF_INTERVAL / 2);

  logic [NUM_BANKS-1:0] bankOpen;
  logic [NUM_BANKS-1:0] bankReady;
  logic [ROW_W-1:0]     bankRow [NUM_BANKS];

  // per-bank row state and spacing counter
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic             picked;
    logic             closeNow;
    logic             openQ;
    logic [ROW_W-1:0] rowQ;
    logic [GAP_W-1:0] cntQ;

    assign picked   = (selBank == BANK_W'(b));
    assign closeNow = picked && (strobe.doPre || (strobe.doAccess && strobe.autoPre));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        openQ <= 1'b0;
        rowQ  <= '0;
        cntQ  <= '0;
      end else begin
        if (strobe.doRef)                cntQ <= GAP_W'(REF_GAP - 1);
        else if (picked && strobe.doAct) cntQ <= GAP_W'(ACT_GAP - 1);
        else if (closeNow)               cntQ <= GAP_W'(PRE_GAP - 1);
        else if (cntQ != '0)             cntQ <= cntQ - 1'b1;

        if (picked && strobe.doAct) begin
          openQ <= 1'b1;
          rowQ  <= reqRow;
        end else if (closeNow) begin
          openQ <= 1'b0;
        end
      end
    end

    assign bankOpen[b]  = openQ;
    assign bankReady[b] = (cntQ == '0);
    assign bankRow[b]   = rowQ;

    AST_GAP_RESPECTED: assert property (@(posedge clk) disable iff (!rstN)
      (picked && (strobe.doAct || strobe.doPre || strobe.doAccess)) |-> (cntQ == '0))
      else $error("bank command inside its gap window"); // R3
  end

  // refresh timer, interval halved while hot
  logic [REF_W-1:0] refCnt;
  logic [REF_W-1:0] refLimit;
  logic             refExpire;

  assign refLimit  = hotFlag ? HALF_LIM : FULL_LIM;
  assign refExpire = (refCnt >= refLimit - 1'b1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refCnt     <= '0;
      refPending <= 1'b0;
    end else begin
      refCnt <= refExpire ? '0 : refCnt + 1'b1;
      if (refExpire)          refPending <= 1'b1;
      else if (strobe.doRef)  refPending <= 1'b0;
    end
  end

  // status toward the controller
  assign reqOpen        = bankOpen[reqBank];
  assign reqHit         = (bankRow[reqBank] == reqRow);
  assign reqBankReady   = bankReady[reqBank];
  assign anyOpen        = |bankOpen;
  assign allReady       = &bankReady;
  assign firstOpenReady = bankReady[firstOpen];

  always_comb begin
    firstOpen = '0;
    for (int i = NUM_BANKS - 1; i >= 0; i--) begin
      if (bankOpen[i]) firstOpen = BANK_W'(i);
    end
  end

  // registered command outputs
  seqCmd_e nextCode;
  always_comb begin
    if (strobe.doRef)          nextCode = CMD_REF;
    else if (strobe.doPre)     nextCode = CMD_PRE;
    else if (strobe.doAct)     nextCode = CMD_ACT;
    else if (strobe.doAccess)  nextCode = strobe.isWrite ? CMD_WR : CMD_RD;
    else                       nextCode = CMD_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdValid   <= 1'b0;
      cmdCode    <= CMD_IDLE;
      cmdBank    <= '0;
      cmdAddr    <= '0;
      cmdAutoPre <= 1'b0;
    end else begin
      cmdValid   <= strobe.doAct | strobe.doPre | strobe.doAccess | strobe.doRef;
      cmdCode    <= nextCode;
      cmdBank    <= strobe.doRef ? '0 : selBank;
      cmdAutoPre <= strobe.doAccess & strobe.autoPre;
      if (strobe.doAct)         cmdAddr <= ADDR_W'(reqRow);
      else if (strobe.doAccess) cmdAddr <= ADDR_W'(reqCol);
      else                      cmdAddr <= '0;
    end
  end

  AST_ACT_ONLY_CLOSED: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doAct |-> !bankOpen[selBank])
    else $error("activate to an open bank"); // R2

  AST_ACCESS_ON_HIT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doAccess |-> (bankOpen[selBank] && bankRow[selBank] == reqRow))
    else $error("access without the requested row open"); // R4

  AST_REF_ALL_CLOSED: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doRef |-> (bankOpen == '0))
    else $error("refresh with a bank still open"); // R8

  AST_IDLE_CODE: assert property (@(posedge clk) disable iff (!rstN)
    !cmdValid |-> (cmdCode == CMD_IDLE))
    else $error("nonzero code without strobe"); // R7

endmodule

// File: rtl/rowSeqCtrl.sv
module rowSeqCtrl
  import rowseq_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  localparam int BANK_W = $clog2(NUM_BANKS)
) (
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqAutoPre,
  input  logic [BANK_W-1:0] reqBank,
  input  logic              reqOpen,
  input  logic              reqHit,
  input  logic              reqBankReady,
  input  logic              refPending,
  input  logic              anyOpen,
  input  logic [BANK_W-1:0] firstOpen,
  input  logic              firstOpenReady,
  input  logic              allReady,
  output seqStrobe_t        strobe,
  output logic [BANK_W-1:0] selBank,
  output logic              reqReady
);

  always_comb begin
    strobe  = '0;
    selBank = reqBank;
    if (refPending) begin
      // refresh wins: close banks lowest first, then refresh
      selBank = firstOpen;
      if (anyOpen) strobe.doPre = firstOpenReady;
      else         strobe.doRef = allReady;
    end else if (reqValid && reqBankReady) begin
      if (!reqOpen) begin
        strobe.doAct = 1'b1;
      end else if (!reqHit) begin
        strobe.doPre = 1'b1;
      end else begin
        strobe.doAccess = 1'b1;
        strobe.isWrite  = reqWrite;
        strobe.autoPre  = reqAutoPre;
      end
    end
  end

  assign reqReady = strobe.doAccess;

endmodule

// File: rtl/rowCmdSeq.sv
module rowCmdSeq
  import rowseq_pkg::*;
#(
  parameter int NUM_BANKS    = 8,
  parameter int ROW_W        = 14,
  parameter int COL_W        = 10,
  parameter int ACT_GAP      = 3,
  parameter int PRE_GAP      = 2,
  parameter int REF_GAP      = 4,
  parameter int REF_INTERVAL = 7800,
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hotFlag,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqAutoPre,
  input  logic [BANK_W-1:0] reqBank,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic [COL_W-1:0]  reqCol,
  output logic              reqReady,
  output logic              cmdValid,
  output logic [2:0]        cmdCode,
  output logic [BANK_W-1:0] cmdBank,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic              cmdAutoPre
);

  seqStrobe_t        strobe;
  logic [BANK_W-1:0] selBank;
  logic              reqOpen, reqHit, reqBankReady, refPending;
  logic              anyOpen, firstOpenReady, allReady;
  logic [BANK_W-1:0] firstOpen;

  rowSeqCtrl #(.NUM_BANKS(NUM_BANKS)) u_ctrl (
    .reqValid      (reqValid),
    .reqWrite      (reqWrite),
    .reqAutoPre    (reqAutoPre),
    .reqBank       (reqBank),
    .reqOpen       (reqOpen),
    .reqHit        (reqHit),
    .reqBankReady  (reqBankReady),
    .refPending    (refPending),
    .anyOpen       (anyOpen),
    .firstOpen     (firstOpen),
    .firstOpenReady(firstOpenReady),
    .allReady      (allReady),
    .strobe        (strobe),
    .selBank       (selBank),
    .reqReady      (reqReady)
  );

  rowSeqPath #(
    .NUM_BANKS   (NUM_BANKS),
    .ROW_W       (ROW_W),
    .COL_W       (COL_W),
    .ACT_GAP     (ACT_GAP),
    .PRE_GAP     (PRE_GAP),
    .REF_GAP     (REF_GAP),
    .REF_INTERVAL(REF_INTERVAL)
  ) u_path (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .selBank       (selBank),
    .reqBank       (reqBank),
    .reqRow        (reqRow),
    .reqCol        (reqCol),
    .hotFlag       (hotFlag),
    .reqOpen       (reqOpen),
    .reqHit        (reqHit),
    .reqBankReady  (reqBankReady),
    .refPending    (refPending),
    .anyOpen       (anyOpen),
    .firstOpen     (firstOpen),
    .firstOpenReady(firstOpenReady),
    .allReady      (allReady),
    .cmdValid      (cmdValid),
    .cmdCode       (cmdCode),
    .cmdBank       (cmdBank),
    .cmdAddr       (cmdAddr),
    .cmdAutoPre    (cmdAutoPre)
  );

  AST_READY_THEN_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |=> (cmdValid && (cmdCode == CMD_RD || cmdCode == CMD_WR)
                  && cmdBank == $past(reqBank)))
    else $error("accepted request not followed by its access"); // R7

endmodule

// File: tb/tb_rowCmdSeq.sv
`timescale 1ns/1ps
module tb_rowCmdSeq;

  localparam int ACT_GAP = 3;
  localparam int PRE_GAP = 2;
  localparam int REF_IV  = 400;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hotFlag = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic        reqAutoPre = 1'b0;
  logic [2:0]  reqBank = '0;
  logic [13:0] reqRow = '0;
  logic [9:0]  reqCol = '0;
  logic        reqReady;
  logic        cmdValid;
  logic [2:0]  cmdCode;
  logic [2:0]  cmdBank;
  logic [13:0] cmdAddr;
  logic        cmdAutoPre;

  int cycleCnt = 0;
  int checks = 0;
  int fails = 0;
  int logN;
  int logCode [16];
  int logBank [16];
  int logAddr [16];
  int logAp   [16];
  int logCyc  [16];

  always #2 clk = ~clk;
  always @(posedge clk) cycleCnt <= cycleCnt + 1;

  rowCmdSeq #(
    .ACT_GAP(ACT_GAP), .PRE_GAP(PRE_GAP), .REF_GAP(4), .REF_INTERVAL(REF_IV)
  ) dut (
    .clk(clk), .rstN(rstN), .hotFlag(hotFlag), .reqValid(reqValid),
    .reqWrite(reqWrite), .reqAutoPre(reqAutoPre), .reqBank(reqBank),
    .reqRow(reqRow), .reqCol(reqCol), .reqReady(reqReady),
    .cmdValid(cmdValid), .cmdCode(cmdCode), .cmdBank(cmdBank),
    .cmdAddr(cmdAddr), .cmdAutoPre(cmdAutoPre)
  );

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // present one request and log every command until its access appears
  task automatic runReq(input bit wr, input bit ap, input int bank, input int row, input int col);
    bit takenNow;
    logN = 0;
    reqValid = 1'b1; reqWrite = wr; reqAutoPre = ap;
    reqBank = 3'(bank); reqRow = 14'(row); reqCol = 10'(col);
    for (int i = 0; i < 300; i++) begin
      #1;
      takenNow = reqReady;
      @(negedge clk);
      if (cmdValid && logN < 16) begin
        logCode[logN] = int'(cmdCode);
        logBank[logN] = int'(cmdBank);
        logAddr[logN] = int'(cmdAddr);
        logAp[logN]   = int'(cmdAutoPre);
        logCyc[logN]  = cycleCnt;
        logN++;
      end
      if (takenNow) begin
        reqValid = 1'b0;
        return;
      end
    end
    reqValid = 1'b0;
    check(1'b0, "R7 request never accepted", 0, 1);
  endtask

  task automatic waitRef(output int cyc);
    cyc = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (cmdValid && cmdCode == 3'd5) begin
        cyc = cycleCnt;
        return;
      end
    end
    check(1'b0, "R8 refresh never seen", 0, 1);
  endtask

  task automatic syncRef(output int cyc);
    int r;
    waitRef(r);
    waitRef(cyc);
  endtask

  task automatic testReset();
    @(negedge clk);
    check(cmdValid == 1'b0, "R1 no command after reset", int'(cmdValid), 0);
    check(reqReady == 1'b0, "R1 reqReady low after reset", int'(reqReady), 0);
    check(cmdCode == 3'd0, "R7 idle code", int'(cmdCode), 0);
  endtask

  task automatic testClosed();
    runReq(1'b0, 1'b0, 3, 'h123, 'h45);
    check(logN == 2, "R2 command count for closed bank", logN, 2);
    check(logCode[0] == 1, "R2 first command is activate", logCode[0], 1);
    check(logBank[0] == 3, "R2 activate bank", logBank[0], 3);
    check(logAddr[0] == 'h123, "R2 activate row", logAddr[0], 'h123);
    check(logCode[1] == 2, "R7 access follows reqReady", logCode[1], 2);
    check(logAddr[1] == 'h45, "R3 read column", logAddr[1], 'h45);
    check(logCyc[1] - logCyc[0] == ACT_GAP, "R3 activate to read spacing",
          logCyc[1] - logCyc[0], ACT_GAP);
  endtask

  task automatic testHit();
    int startCyc;
    startCyc = cycleCnt;
    runReq(1'b1, 1'b0, 3, 'h123, 'h10);
    check(logN == 1, "R4 hit issues one command", logN, 1);
    check(logCode[0] == 3, "R4 hit is a write", logCode[0], 3);
    check(logAddr[0] == 'h10, "R4 write column", logAddr[0], 'h10);
    check(logCyc[0] - startCyc == 1, "R4 hit latency", logCyc[0] - startCyc, 1);
  endtask

  task automatic testMiss();
    runReq(1'b0, 1'b0, 3, 'h55, 'h20);
    check(logN == 3, "R5 miss command count", logN, 3);
    check(logCode[0] == 4 && logBank[0] == 3, "R5 precharge first", logCode[0], 4);
    check(logCode[1] == 1 && logAddr[1] == 'h55, "R5 activate new row", logAddr[1], 'h55);
    check(logCyc[1] - logCyc[0] == PRE_GAP, "R5 precharge to activate",
          logCyc[1] - logCyc[0], PRE_GAP);
    check(logCyc[2] - logCyc[1] == ACT_GAP, "R5 activate to read",
          logCyc[2] - logCyc[1], ACT_GAP);
  endtask

  task automatic testAutoClose();
    int apCyc;
    runReq(1'b0, 1'b1, 3, 'h55, 7);
    check(logN == 1 && logCode[0] == 2, "R6 auto-close read issued", logCode[0], 2);
    check(logAp[0] == 1, "R6 auto-close flag", logAp[0], 1);
    apCyc = logCyc[0];
    runReq(1'b0, 1'b0, 3, 'h55, 8);
    check(logN == 2 && logCode[0] == 1, "R6 same row needs activate", logCode[0], 1);
    check(logCyc[0] - apCyc == PRE_GAP, "R6 activate spacing after auto-close",
          logCyc[0] - apCyc, PRE_GAP);
  endtask

  task automatic testBanks();
    int r;
    syncRef(r);
    runReq(1'b0, 1'b0, 1, 'h0AA, 1);
    runReq(1'b1, 1'b0, 6, 'h0BB, 2);
    check(logN == 2 && logCode[0] == 1, "R10 second bank activated", logCode[0], 1);
    runReq(1'b0, 1'b0, 1, 'h0AA, 3);
    check(logN == 1 && logCode[0] == 2 && logBank[0] == 1, "R10 first bank row kept",
          logN, 1);
    runReq(1'b1, 1'b0, 6, 'h0BB, 4);
    check(logN == 1 && logCode[0] == 3 && logBank[0] == 6, "R10 second bank row kept",
          logN, 1);
  endtask

  task automatic testRefreshPriority();
    int r;
    syncRef(r);
    runReq(1'b0, 1'b0, 2, 'h77, 1);
    while (cycleCnt < r + REF_IV - 1) @(negedge clk);
    runReq(1'b0, 1'b0, 5, 'h99, 2);
    check(logN == 4, "R8 command count around refresh", logN, 4);
    check(logCode[0] == 4 && logBank[0] == 2, "R8 open bank precharged first", logCode[0], 4);
    check(logCode[1] == 5, "R8 refresh before request", logCode[1], 5);
    check(logCode[2] == 1 && logBank[2] == 5, "R8 request served after refresh", logCode[2], 1);
    check(logCode[3] == 2, "R8 request access", logCode[3], 2);
  endtask

  task automatic testIntervals();
    int a, b, c;
    waitRef(a); waitRef(b); waitRef(c);
    check(c - b == REF_IV, "R8 refresh interval", c - b, REF_IV);
    hotFlag = 1'b1;
    waitRef(a); waitRef(b); waitRef(c);
    check(c - b == REF_IV / 2, "R9 hot refresh interval", c - b, REF_IV / 2);
    hotFlag = 1'b0;
  endtask

  initial begin
    wait (cycleCnt >= 150000);
    check(1'b0, "watchdog expired", cycleCnt, 0);
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testClosed();
    testHit();
    testMiss();
    testAutoClose();
    testBanks();
    testRefreshPriority();
    testIntervals();
    report();
  end

endmodule